// File: doc/BRIEF.md
# 8-bit ALU with registered status flags

This block is the execute stage of a small accumulator machine. It computes an 8-bit result without a clock edge from the accumulator, one operand byte and the flags it holds. It also holds the five status flags in a register of its own. The flags are sign S, zero Z, half carry AC, parity P and carry CY. On a clock edge where `op_valid_i` is high, that register takes the new flags of the selected operation. Each class of operation writes only its own subset of flags. The same block adds a 16-bit register pair into HL, and that operation touches only the carry.

The caller supplies the operands and writes the results back. It writes `res_o` into the accumulator or into the target register when `res_we_o` is high, and it writes `hl_o` into HL when `hl_we_o` is high. Compare and the carry-only operations write nothing but the flags. The flag register is the carry source for ADC, SBB, RAL and RAR. It is also the source of every flag that an operation leaves unchanged.

Top module: `alu8_flags`

## Requirements
- R1: While `rst_ni` is low, `flags_o` is 0. `flags_o` bits 4..0 are S, Z, AC, P and CY. When `op_valid_i` is low, `res_we_o` and `hl_we_o` are 0.
- R2: ADD (op 0) gives acc+opnd, and ADC (op 1) gives acc+opnd+CY. Both write the result and set all five flags. S is result bit 7, Z is 1 for a zero result, and P is 1 for an even count of ones. AC is the carry out of bit 3, and CY is the carry out of bit 7.
- R3: SUB (op 2) gives acc−opnd, and SBB (op 3) gives acc−opnd−CY, both in two's complement. Both write the result. S, Z and P follow the result, AC is the borrow out of bit 3, and CY is 1 on a borrow out of bit 7.
- R4: CMP (op 4) writes no result. It sets CY when acc<opnd and Z when acc=opnd, and clears both when acc>opnd. S, P and AC follow the difference, as for SUB.
- R5: AND (op 5) writes acc&opnd. S, Z and P follow the result, CY becomes 0 and AC becomes 1.
- R6: OR (op 6) and XOR (op 7) write acc|opnd and acc^opnd. S, Z and P follow the result, and CY and AC become 0.
- R7: Rotate left (op 8) moves acc bit 7 into bit 0 and into CY. Rotate right (op 9) moves acc bit 0 into bit 7 and into CY.
- R8: Rotate left through carry (op 10) puts bit 7 into CY and the old CY into bit 0. Rotate right through carry (op 11) puts bit 0 into CY and the old CY into bit 7.
- R9: The four rotates hold S, Z, AC and P.
- R10: Complement accumulator (op 12) writes ~acc and holds all flags. Complement carry (op 13) inverts CY, and set carry (op 14) sets CY. Ops 13 and 14 write no result and hold the other flags.
- R11: Increment (op 15) writes opnd+1 and decrement (op 16) writes opnd−1. AC is the carry or borrow out of bit 3, S, Z and P follow the result, and CY is held.
- R12: The pair add (op 17) drives `hl_o` = hl+pair with `hl_we_o` high and `res_we_o` low. CY takes the carry out of bit 15, and the other flags are held.
- R13: The flags change only on a rising clock edge where `op_valid_i` is high. Before that edge, `res_o` and the write enables are computed from the flags held at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation present this cycle |
| op_i | input | 5 | Operation code (0..17) |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Operand byte |
| hl_i | input | 16 | HL pair value |
| pair_i | input | 16 | Register pair to add into HL |
| res_o | output | 8 | Byte result |
| res_we_o | output | 1 | Write enable for res_o |
| hl_o | output | 16 | Pair-add result |
| hl_we_o | output | 1 | Write enable for hl_o |
| flags_o | output | 5 | Held flags {S, Z, AC, P, CY} |

## Verification
The assertions assume that `op_i` and the operand inputs are settled before the rising edge where `op_valid_i` is high. The compare check reads the operands in the cycle before the flags move, so they must not change between that edge and the sample point. The bench changes inputs only on the falling edge, and it uses only op codes 0 to 17. Before each vector it forces the flags into a known state with an OR of zeros, and when the vector needs a set carry it follows that with a set-carry step. This makes every carry-in and every held flag known in advance.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [4:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7,
    OP_RLC = 5'd8,  OP_RRC = 5'd9,  OP_RAL = 5'd10, OP_RAR = 5'd11,
    OP_CMA = 5'd12, OP_CMC = 5'd13, OP_STC = 5'd14, OP_INR = 5'd15,
    OP_DCR = 5'd16, OP_DAD = 5'd17
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cy_o,
  output logic         hc_o
);
  localparam int H = W / 2;

  logic [W-1:0] y_eff;
  logic         c_eff;
  logic [H:0]   lo;
  logic [W-H:0] hi;

  // subtract as x + ~y + ~borrow; carry outs invert into borrows
  assign y_eff = sub_i ? ~y_i : y_i;
  assign c_eff = sub_i ? ~cin_i : cin_i;
  assign lo    = {1'b0, x_i[H-1:0]} + {1'b0, y_eff[H-1:0]} + {{H{1'b0}}, c_eff};
  assign hi    = {1'b0, x_i[W-1:H]} + {1'b0, y_eff[W-1:H]} + {{(W-H){1'b0}}, lo[H]};
  assign sum_o = {hi[W-H-1:0], lo[H-1:0]};
  assign cy_o  = hi[W-H] ^ sub_i;
  assign hc_o  = lo[H] ^ sub_i;
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cy_i,
  output logic [W-1:0] res_o,
  output logic         cy_o
);
  always_comb begin
    res_o = '0;
    cy_o  = cy_i;
    case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_RLC: begin res_o = {a_i[W-2:0], a_i[W-1]}; cy_o = a_i[W-1]; end
      OP_RRC: begin res_o = {a_i[0], a_i[W-1:1]};   cy_o = a_i[0];   end
      OP_RAL: begin res_o = {a_i[W-2:0], cy_i};     cy_o = a_i[W-1]; end
      OP_RAR: begin res_o = {cy_i, a_i[W-1:1]};     cy_o = a_i[0];   end
      OP_CMA: res_o = ~a_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
  import alu8_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   upd_i,
  input  flags_t nxt_i,
  output flags_t fl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    fl_o <= '0;
    else if (upd_i) fl_o <= nxt_i;
  end

  // R13
  flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(fl_o));
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           op_valid_i,
  input  logic [4:0]     op_i,
  input  logic [W-1:0]   acc_i,
  input  logic [W-1:0]   opnd_i,
  input  logic [2*W-1:0] hl_i,
  input  logic [2*W-1:0] pair_i,
  output logic [W-1:0]   res_o,
  output logic           res_we_o,
  output logic [2*W-1:0] hl_o,
  output logic           hl_we_o,
  output logic [4:0]     flags_o
);
  localparam int PW = 2 * W;

  alu_op_e      op;
  flags_t       fl_q, fl_nxt;
  logic [W-1:0] ax, ay, ar, lr;
  logic         acin, asub, acy, ahc, lcy;
  logic [PW:0]  dad;

  assign op = alu_op_e'(op_i);

  always_comb begin
    ax = acc_i; ay = opnd_i; acin = 1'b0; asub = 1'b0;
    case (op)
      OP_ADC: acin = fl_q.cy;
      OP_SUB, OP_CMP: asub = 1'b1;
      OP_SBB: begin asub = 1'b1; acin = fl_q.cy; end
      OP_INR: begin ax = opnd_i; ay = '0; acin = 1'b1; end
      OP_DCR: begin ax = opnd_i; ay = {{(W-1){1'b0}}, 1'b1}; asub = 1'b1; end
      default: ;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .x_i(ax), .y_i(ay), .cin_i(acin), .sub_i(asub),
    .sum_o(ar), .cy_o(acy), .hc_o(ahc)
  );

  alu8_logic #(.W(W)) u_logic (
    .op_i(op), .a_i(acc_i), .b_i(opnd_i), .cy_i(fl_q.cy),
    .res_o(lr), .cy_o(lcy)
  );

  assign dad = {1'b0, hl_i} + {1'b0, pair_i};

  always_comb begin
    fl_nxt = fl_q;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP:
        fl_nxt = '{s: ar[W-1], z: (ar == '0), ac: ahc, p: ~^ar, cy: acy};
      OP_AND:
        fl_nxt = '{s: lr[W-1], z: (lr == '0), ac: 1'b1, p: ~^lr, cy: 1'b0};
      OP_OR, OP_XOR:
        fl_nxt = '{s: lr[W-1], z: (lr == '0), ac: 1'b0, p: ~^lr, cy: 1'b0};
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: fl_nxt.cy = lcy;
      OP_CMC: fl_nxt.cy = ~fl_q.cy;
      OP_STC: fl_nxt.cy = 1'b1;
      OP_INR, OP_DCR:
        fl_nxt = '{s: ar[W-1], z: (ar == '0), ac: ahc, p: ~^ar, cy: fl_q.cy};
      OP_DAD: fl_nxt.cy = dad[PW];
      default: ;
    endcase
  end

  alu8_flagreg u_flagreg (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(op_valid_i),
    .nxt_i(fl_nxt), .fl_o(fl_q)
  );

  always_comb begin
    res_o    = '0;
    res_we_o = 1'b0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_INR, OP_DCR: begin
        res_o = ar; res_we_o = op_valid_i;
      end
      OP_CMP: res_o = ar;
      OP_AND, OP_OR, OP_XOR, OP_RLC, OP_RRC, OP_RAL, OP_RAR, OP_CMA: begin
        res_o = lr; res_we_o = op_valid_i;
      end
      default: ;
    endcase
  end

  assign hl_o    = dad[PW-1:0];
  assign hl_we_o = op_valid_i && (op == OP_DAD);
  assign flags_o = fl_q;

  // R4
  cmp_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op == OP_CMP) |=>
      (fl_q.cy == ($past(acc_i) < $past(opnd_i))) &&
      (fl_q.z == ($past(acc_i) == $past(opnd_i))));

  // R5
  and_ac_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op == OP_AND) |=> (fl_q.ac && !fl_q.cy));

  // R9
  rot_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (op == OP_RLC || op == OP_RRC || op == OP_RAL || op == OP_RAR)) |=>
      ($stable(fl_q.s) && $stable(fl_q.z) && $stable(fl_q.ac) && $stable(fl_q.p)));

  // R10
  cma_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op == OP_CMA) |=> $stable(fl_q));

  // R11
  incdec_cy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (op == OP_INR || op == OP_DCR)) |=> $stable(fl_q.cy));

  // R12
  dad_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op == OP_DAD) |=>
      ($stable(fl_q.s) && $stable(fl_q.z) && $stable(fl_q.ac) && $stable(fl_q.p)));

  // R12
  dad_no_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hl_we_o |-> !res_we_o);
endmodule

// File: tb/alu8_flags_tb_top.sv
module alu8_flags_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 28;

  typedef struct packed {
    logic [1:0] pre;
    logic [4:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] res;
    logic       we;
    logic [4:0] fl;
  } vec_t;

  // pre: 1 = flags forced to 01010 (CY 0), 2 = flags forced to 01011 (CY 1)
  localparam logic [36:0] VECS [NV] = '{
    {2'd1, 5'd0,  8'h3A, 8'h47, 8'h81, 1'b1, 5'b10110},
    {2'd1, 5'd0,  8'hFF, 8'h01, 8'h00, 1'b1, 5'b01111},
    {2'd2, 5'd1,  8'h10, 8'h20, 8'h31, 1'b1, 5'b00000},
    {2'd1, 5'd2,  8'h50, 8'h20, 8'h30, 1'b1, 5'b00010},
    {2'd1, 5'd2,  8'h10, 8'h20, 8'hF0, 1'b1, 5'b10011},
    {2'd2, 5'd3,  8'h05, 8'h03, 8'h01, 1'b1, 5'b00000},
    {2'd2, 5'd3,  8'h00, 8'h00, 8'hFF, 1'b1, 5'b10111},
    {2'd1, 5'd4,  8'h20, 8'h40, 8'h00, 1'b0, 5'b10001},
    {2'd2, 5'd4,  8'h42, 8'h42, 8'h00, 1'b0, 5'b01010},
    {2'd2, 5'd4,  8'h90, 8'h11, 8'h00, 1'b0, 5'b00100},
    {2'd2, 5'd5,  8'hF0, 8'h3C, 8'h30, 1'b1, 5'b00110},
    {2'd2, 5'd5,  8'h0F, 8'hF0, 8'h00, 1'b1, 5'b01110},
    {2'd2, 5'd6,  8'h80, 8'h01, 8'h81, 1'b1, 5'b10010},
    {2'd2, 5'd7,  8'hAA, 8'hFF, 8'h55, 1'b1, 5'b00010},
    {2'd1, 5'd8,  8'h81, 8'h00, 8'h03, 1'b1, 5'b01011},
    {2'd1, 5'd9,  8'h01, 8'h00, 8'h80, 1'b1, 5'b01011},
    {2'd1, 5'd10, 8'h80, 8'h00, 8'h00, 1'b1, 5'b01011},
    {2'd2, 5'd10, 8'h01, 8'h00, 8'h03, 1'b1, 5'b01010},
    {2'd2, 5'd11, 8'h00, 8'h00, 8'h80, 1'b1, 5'b01010},
    {2'd1, 5'd11, 8'h01, 8'h00, 8'h00, 1'b1, 5'b01011},
    {2'd2, 5'd12, 8'h5A, 8'h00, 8'hA5, 1'b1, 5'b01011},
    {2'd2, 5'd13, 8'h00, 8'h00, 8'h00, 1'b0, 5'b01010},
    {2'd1, 5'd13, 8'h00, 8'h00, 8'h00, 1'b0, 5'b01011},
    {2'd1, 5'd14, 8'h00, 8'h00, 8'h00, 1'b0, 5'b01011},
    {2'd2, 5'd15, 8'h00, 8'h0F, 8'h10, 1'b1, 5'b00101},
    {2'd1, 5'd15, 8'h00, 8'hFF, 8'h00, 1'b1, 5'b01110},
    {2'd2, 5'd16, 8'h00, 8'h10, 8'h0F, 1'b1, 5'b00111},
    {2'd2, 5'd16, 8'h00, 8'h01, 8'h00, 1'b1, 5'b01011}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [4:0]  op = '0;
  logic [7:0]  acc = '0, opnd = '0;
  logic [15:0] hl = '0, pair = '0;
  logic [7:0]  res;
  logic        res_we, hl_we;
  logic [15:0] hl_res;
  logic [4:0]  flags;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0]  c_res;
  logic        c_we, c_hlwe;
  logic [15:0] c_hl;
  logic [4:0]  c_fl;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_flags dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(valid), .op_i(op),
    .acc_i(acc), .opnd_i(opnd), .hl_i(hl), .pair_i(pair),
    .res_o(res), .res_we_o(res_we), .hl_o(hl_res), .hl_we_o(hl_we),
    .flags_o(flags)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [4:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic [15:0] h, input logic [15:0] p);
    @(negedge clk);
    op = o; acc = a; opnd = b; hl = h; pair = p; valid = 1'b1;
    #1;
    c_res = res; c_we = res_we; c_hl = hl_res; c_hlwe = hl_we;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    #1;
    c_fl = flags;
  endtask

  task automatic prep(input logic [1:0] pre);
    if (pre != 2'd0) do_op(5'd6, 8'h00, 8'h00, 16'h0, 16'h0);
    if (pre == 2'd2) do_op(5'd14, 8'h00, 8'h00, 16'h0, 16'h0);
  endtask

  function automatic string tag_of(input logic [4:0] o, input bit flag_chk);
    case (o)
      5'd0, 5'd1:   return "R2";
      5'd2, 5'd3:   return "R3";
      5'd4:         return "R4";
      5'd5:         return "R5";
      5'd6, 5'd7:   return "R6";
      5'd8, 5'd9:   return flag_chk ? "R9" : "R7";
      5'd10, 5'd11: return flag_chk ? "R9" : "R8";
      5'd15, 5'd16: return "R11";
      default:      return "R10";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog R13 actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R1 flags in reset", {27'd0, flags}, 32'h0);
    chk("R1 res_we idle", {31'd0, res_we}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 flags after reset", {27'd0, flags}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      prep(v.pre);
      do_op(v.op, v.a, v.b, 16'h0, 16'h0);
      if (v.we) chk({tag_of(v.op, 1'b0), " result"}, {24'd0, c_res}, {24'd0, v.res});
      chk({tag_of(v.op, 1'b0), " write enable"}, {31'd0, c_we}, {31'd0, v.we});
      chk({tag_of(v.op, 1'b1), " flags"}, {27'd0, c_fl}, {27'd0, v.fl});
    end

    // R12: pair add with carry out of bit 15
    prep(2'd1);
    do_op(5'd17, 8'h00, 8'h00, 16'hFFFF, 16'h0002);
    chk("R12 hl sum wrap", {16'd0, c_hl}, 32'h0001);
    chk("R12 hl_we", {31'd0, c_hlwe}, 32'h1);
    chk("R12 res_we low", {31'd0, c_we}, 32'h0);
    chk("R12 flags carry", {27'd0, c_fl}, {27'd0, 5'b01011});
    prep(2'd2);
    do_op(5'd17, 8'h00, 8'h00, 16'h1234, 16'h1111);
    chk("R12 hl sum", {16'd0, c_hl}, 32'h2345);
    chk("R12 flags no carry", {27'd0, c_fl}, {27'd0, 5'b01010});

    // R13: no valid, no flag change; change lands at the edge
    prep(2'd1);
    @(negedge clk);
    op = 5'd14; valid = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R13 held without valid", {27'd0, flags}, {27'd0, 5'b01010});
    chk("R1 no write without valid", {30'd0, res_we, hl_we}, 32'h0);
    @(negedge clk);
    op = 5'd13; valid = 1'b1;
    #1;
    chk("R13 before edge", {27'd0, flags}, {27'd0, 5'b01010});
    @(posedge clk);
    #1;
    chk("R13 after edge", {27'd0, flags}, {27'd0, 5'b01011});
    @(negedge clk);
    valid = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule